// File: doc/BRIEF.md
# Keyed Software Reset Line Controller

This block gives software direct control over a bank of peripheral reset lines through two 32-bit registers on a simple register bus. One register holds the requested state of each line. Writes to it take effect only if they carry a fixed key byte, so a stray write cannot reset a peripheral. A second register is an enable mask that needs no key. A line is driven only while its mask bit is set.

Software is expected to set the mask bit first, then assert the line, then deassert it, then clear the mask bit. A pulse reset is one assert write followed by one deassert write. Both registers can be read back. Synchronisation of the lines into their target clock domains and any reset sequencing there happen outside this block.

Top module: `keyed_rst_ctrl`

## Requirements
- R1: After reset both registers read as zero and every line in `resetLines` is low.
- R2: A write to the line register at offset 0x18 whose bits [31:24] equal 0x88 loads bits [NUM_LINES-1:0] into it, and bit n controls line n. The new value is visible after the capturing clock edge.
- R3: A write to offset 0x18 with any other value in bits [31:24] leaves the line register unchanged.
- R4: A write to the mask register at offset 0xFC loads bits [NUM_LINES-1:0] whatever bits [31:24] hold.
- R5: `resetLines[n]` is high exactly when line bit n and mask bit n are both 1. Clearing a mask bit releases its line from the next edge even if the line bit is still set.
- R6: Bits at and above NUM_LINES read as zero in both registers, and writing ones there has no effect.
- R7: Reading offset 0x18 returns the stored line bits with bits [31:24] zero. Reading 0xFC returns the mask. Any other offset reads zero.
- R8: A write to any offset other than 0x18 or 0xFC changes neither register.
- R9: With a line's mask bit set, an assert write followed by a deassert write drives that line high for exactly the cycles between the two capturing edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register bus and register clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWrite | input | 1 | Write strobe, sampled on the rising clock edge |
| busAddr | input | ADDR_W | Byte offset of the access |
| busWdata | input | 32 | Write data; bits [31:24] carry the key for the line register |
| busRdata | output | 32 | Read data for busAddr, combinational |
| resetLines | output | NUM_LINES | Active-high reset lines, line bit AND mask bit |

## Verification
The bench builds the block with NUM_LINES set to 20 instead of the default 24. This leaves bits 20 to 23 below the key byte as unimplemented positions. Writes of all ones, both keyed and unkeyed, can then show that those bits stay zero and that the key byte never reads back. The defaults keep the 0x18 and 0xFC offsets and the 0x88 key, so the near-miss key 0x89, the wrong key 0x12, a write to an unmapped offset and a mask clear under an asserted line all land on the same register layout that software uses.

// File: rtl/keyrst_pkg.sv
package keyrst_pkg;
  // Write strobes issued by the decoder to the register datapath.
  typedef struct packed {
    logic lineWrite;
    logic maskWrite;
  } strobe_t;
endpackage

// File: rtl/keyrst_ctrl.sv
module keyrst_ctrl
  import keyrst_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] LINE_ADDR = 'h18,
  parameter logic [ADDR_W-1:0] MASK_ADDR = 'hFC,
  parameter logic [7:0] KEY = 8'h88
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [7:0]        keyByte,
  output strobe_t           strobes
);
  logic hitLine;
  logic hitMask;
  logic keyOk;

  assign hitLine = (busAddr == LINE_ADDR);
  assign hitMask = (busAddr == MASK_ADDR);
  assign keyOk   = (keyByte == KEY);

  always_comb begin
    strobes = '0;
    if (busWrite) begin
      strobes.lineWrite = hitLine && keyOk;
      strobes.maskWrite = hitMask;
    end
  end

  // R8: a single access never writes both registers
  a_r8_one_strobe: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.lineWrite, strobes.maskWrite}));
endmodule

// File: rtl/keyrst_dp.sv
module keyrst_dp
  import keyrst_pkg::*;
#(
  parameter int NUM_LINES = 24,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] LINE_ADDR = 'h18,
  parameter logic [ADDR_W-1:0] MASK_ADDR = 'hFC
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  strobe_t              strobes,
  input  logic [NUM_LINES-1:0] wrBits,
  input  logic [ADDR_W-1:0]    rdAddr,
  output logic [31:0]          rdData,
  output logic [NUM_LINES-1:0] lineOut
);
  logic [NUM_LINES-1:0] lineReg;
  logic [NUM_LINES-1:0] maskReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lineReg <= '0;
    end else if (strobes.lineWrite) begin
      lineReg <= wrBits;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskReg <= '0;
    end else if (strobes.maskWrite) begin
      maskReg <= wrBits;
    end
  end

  // One gate per line: the line is driven only while its mask bit is set.
  for (genvar i = 0; i < NUM_LINES; i++) begin : g_gate
    assign lineOut[i] = lineReg[i] & maskReg[i];
  end

  always_comb begin
    rdData = '0;
    if (rdAddr == LINE_ADDR) begin
      rdData[NUM_LINES-1:0] = lineReg;
    end else if (rdAddr == MASK_ADDR) begin
      rdData[NUM_LINES-1:0] = maskReg;
    end
  end

  // R3: without a line strobe the line register holds its value
  a_r3_line_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.lineWrite |=> $stable(lineReg));

  // R8: without a mask strobe the mask register holds its value
  a_r8_mask_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.maskWrite |=> $stable(maskReg));
endmodule

// File: rtl/keyed_rst_ctrl.sv
module keyed_rst_ctrl
  import keyrst_pkg::*;
#(
  parameter int NUM_LINES = 24,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] LINE_ADDR = 'h18,
  parameter logic [ADDR_W-1:0] MASK_ADDR = 'hFC,
  parameter logic [7:0] KEY = 8'h88
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 busWrite,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic [31:0]          busWdata,
  output logic [31:0]          busRdata,
  output logic [NUM_LINES-1:0] resetLines
);
  localparam int KEY_LSB = 24;

  strobe_t strobes;
  logic    unusedWdata;

  assign unusedWdata = &{1'b0, busWdata};

  keyrst_ctrl #(
    .ADDR_W(ADDR_W), .LINE_ADDR(LINE_ADDR), .MASK_ADDR(MASK_ADDR), .KEY(KEY)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .busWrite(busWrite), .busAddr(busAddr),
    .keyByte(busWdata[31:KEY_LSB]), .strobes(strobes)
  );

  keyrst_dp #(
    .NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W),
    .LINE_ADDR(LINE_ADDR), .MASK_ADDR(MASK_ADDR)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .wrBits(busWdata[NUM_LINES-1:0]), .rdAddr(busAddr),
    .rdData(busRdata), .lineOut(resetLines)
  );

  // R2: a keyed write to the line offset shows up on read-back next cycle
  a_r2_keyed_load: assert property (@(posedge clk) disable iff (!rstN)
    (busWrite && busAddr == LINE_ADDR && busWdata[31:KEY_LSB] == KEY
     && $stable(busAddr))
    |=> (busAddr != LINE_ADDR) || (busRdata[NUM_LINES-1:0] == $past(busWdata[NUM_LINES-1:0])));

  // R5: writing an all-zero mask releases every line from the next edge
  a_r5_release: assert property (@(posedge clk) disable iff (!rstN)
    (busWrite && busAddr == MASK_ADDR && busWdata[NUM_LINES-1:0] == '0)
    |=> resetLines == '0);

  // R6: positions above the line count always read zero
  a_r6_upper_zero: assert property (@(posedge clk) disable iff (!rstN)
    busRdata[31:NUM_LINES] == '0);
endmodule

// File: tb/keyed_rst_ctrl_test.sv
`timescale 1ns/1ps
module keyed_rst_ctrl_test;
  localparam int N = 20;
  localparam logic [7:0] LA = 8'h18;
  localparam logic [7:0] MA = 8'hFC;
  localparam int NV = 12;

  // Each row: offset, write data, expected line read, mask read, lines
  localparam logic [7:0]  V_ADDR [NV] = '{MA, LA, LA, LA, MA, MA, 8'h10, LA, MA, LA, LA, MA};
  localparam logic [31:0] V_DATA [NV] = '{
    32'h0000_000F, 32'h8800_0005, 32'h1200_00FF, 32'h8800_00F3,
    32'hAB00_0001, 32'h0000_0000, 32'h88FF_FFFF, 32'h88FF_FFFF,
    32'hFFFF_FFFF, 32'h8800_0000, 32'h8900_0001, 32'h0000_0000};
  localparam logic [31:0] V_LINE [NV] = '{
    32'h0, 32'h5, 32'h5, 32'hF3, 32'hF3, 32'hF3, 32'hF3, 32'hFFFFF,
    32'hFFFFF, 32'h0, 32'h0, 32'h0};
  localparam logic [31:0] V_MASK [NV] = '{
    32'hF, 32'hF, 32'hF, 32'hF, 32'h1, 32'h0, 32'h0, 32'h0,
    32'hFFFFF, 32'hFFFFF, 32'hFFFFF, 32'h0};
  localparam logic [31:0] V_OUT [NV] = '{
    32'h0, 32'h5, 32'h5, 32'h3, 32'h1, 32'h0, 32'h0, 32'h0,
    32'hFFFFF, 32'h0, 32'h0, 32'h0};
  // Requirement exercised by each row: R4 R2 R3 R5 R4 R5 R8 R6 R6 R2 R3 R4
  localparam int V_REQ [NV] = '{4, 2, 3, 5, 4, 5, 8, 6, 6, 2, 3, 4};

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWrite = 1'b0;
  logic [7:0]  busAddr = 8'h00;
  logic [31:0] busWdata = 32'h0;
  logic [31:0] busRdata;
  logic [N-1:0] resetLines;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  keyed_rst_ctrl #(.NUM_LINES(N)) uut (
    .clk(clk), .rstN(rstN), .busWrite(busWrite), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .resetLines(resetLines)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic doWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busWrite = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busWrite = 1'b0;
  endtask

  task automatic readAt(input logic [7:0] a, output logic [31:0] d);
    busAddr = a;
    #1;
    d = busRdata;
  endtask

  task automatic checkAll(input string req, input logic [31:0] eLine,
                          input logic [31:0] eMask, input logic [31:0] eOut);
    logic [31:0] rd;
    readAt(LA, rd);
    check({req, " line read"}, rd, eLine);
    readAt(MA, rd);
    check({req, " mask read"}, rd, eMask);
    check({req, " lines"}, {{(32-N){1'b0}}, resetLines}, eOut);
  endtask

  initial begin
    #(8 * 50000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    // R1: reset state
    checkAll("R1", 32'h0, 32'h0, 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    // R7: unmapped offset reads zero
    readAt(8'h10, rd);
    check("R7 unmapped read", rd, 32'h0);

    for (int i = 0; i < NV; i++) begin
      doWrite(V_ADDR[i], V_DATA[i]);
      checkAll($sformatf("R%0d row%0d", V_REQ[i], i), V_LINE[i], V_MASK[i], V_OUT[i]);
    end

    // R9: pulse on line 7 with enable/assert/deassert/disable ordering
    doWrite(MA, 32'h0000_0080);
    check("R9 enabled idle", {{(32-N){1'b0}}, resetLines}, 32'h0);
    doWrite(LA, 32'h8800_0080);
    check("R9 asserted", {{(32-N){1'b0}}, resetLines}, 32'h80);
    doWrite(LA, 32'h8800_0000);
    check("R9 deasserted", {{(32-N){1'b0}}, resetLines}, 32'h0);
    doWrite(MA, 32'h0);

    // R5: mask clear under an asserted line releases it, line bit kept
    doWrite(MA, 32'h0000_0300);
    doWrite(LA, 32'h8800_0300);
    check("R5 both set", {{(32-N){1'b0}}, resetLines}, 32'h300);
    doWrite(MA, 32'h0000_0100);
    checkAll("R5 partial clear", 32'h300, 32'h100, 32'h100);

    // R7: key byte never reads back
    readAt(LA, rd);
    check("R7 key byte zero", {24'h0, rd[31:24]}, 32'h0);

    // R1: reset mid-run clears everything
    @(negedge clk);
    rstN = 1'b0;
    #1;
    checkAll("R1 rerun", 32'h0, 32'h0, 32'h0);
    @(negedge clk);
    rstN = 1'b1;

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule